// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers five interrupt sources (two external pins, two timer overflow flags and one serial-port flag) and offers at most one of them to a CPU as a 16-bit vector address. A master enable and one enable bit per source gate the sources. A priority bit per source puts each source in a high or a low group. Inside a group a fixed order breaks ties. The CPU takes a request with a one-cycle acknowledge and ends the handler with a one-cycle return strobe.

Each external pin is active low. A per-pin mode bit chooses between level triggering, where the request follows the pin, and falling-edge triggering, where a flag inside the block latches the edge and holds it until the CPU acknowledges that source. When a timer source is taken, the block sends a one-cycle clear pulse back to that timer. The serial flag is never cleared from here. The block records which priority levels are in service, so a high-priority request can interrupt a low-priority handler, and nothing can interrupt a high-priority handler.

Top module: `vic_two_level`

## Requirements
- R1: While `glb_en` is 0, `irq_req` stays 0 whatever the sources do.
- R2: Source index i is considered only while `src_en[i]` is 1. The indices are 0 = external pin 0, 1 = timer 0, 2 = external pin 1, 3 = timer 1, 4 = serial.
- R3: The vector is 16'h0003 + 8*index: 0003h, 000Bh, 0013h, 001Bh and 0023h for indices 0 to 4. `irq_vec` is 0 while `irq_req` is 0.
- R4: When several sources with the same priority are pending, the lowest index wins.
- R5: A pending source with `src_pri[i]` = 1 (high) wins over every pending low source, whatever its index.
- R6: With `ext_mode[k]` = 1 (edge mode), a high-to-low change of `ext_pin_n[k]` seen at a clock edge sets `ext_flag[k]` after that edge. The flag then stays set after the pin returns high, and it requests the interrupt.
- R7: With `ext_mode[k]` = 0 (level mode), external source k requests in the same cycle that `ext_pin_n[k]` is low. It stops requesting as soon as the pin goes high, and `ext_flag[k]` stays 0.
- R8: Taking a request (`irq_ack` = 1 while `irq_req` = 1) clears the edge flag of a taken external source from the next cycle on. For a taken timer source, it pulses `tmr_clr[k]` in the acknowledge cycle. It clears nothing for the serial source.
- R9: While only a low-level service is active, only high-priority sources are offered.
- R10: While a high-level service is active, `irq_req` is 0.
- R11: `irq_ret` ends the highest active level from the next cycle on. If a return and an acknowledge come in the same cycle, the return is applied first.
- R12: After reset, no level is in service, both edge flags are 0, and the pin history reads high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| glb_en | input | 1 | Master interrupt enable |
| src_en | input | 5 | Per-source enable, bit i = source index i |
| src_pri | input | 5 | Per-source priority, 1 = high |
| ext_mode | input | 2 | Pin trigger mode, 1 = falling edge, 0 = low level |
| ext_pin_n | input | 2 | External interrupt pins, active low |
| tmr_ovf | input | 2 | Timer overflow flags |
| ser_flag | input | 1 | Serial port interrupt flag |
| irq_ack | input | 1 | CPU takes the offered request |
| irq_ret | input | 1 | CPU returns from a handler |
| irq_req | output | 1 | A request is offered |
| irq_vec | output | 16 | Vector address of the offered request |
| tmr_clr | output | 2 | One-cycle clear pulse to timer k |
| ext_flag | output | 2 | Latched falling-edge flags |

## Verification
`irq_req`, `irq_vec` and `tmr_clr` depend combinationally on the inputs and the stored state, so they are due in the same cycle as their stimulus. An edge flag appears one clock after the edge that sees the falling pin. Changes to the in-service level after an acknowledge or a return show one clock later. The bench changes inputs just after the rising edge and samples every output at the falling edge. A behavioural model updates its flags and service levels only at the rising edge, so every comparison lands in the cycle in which the result is due.

// File: rtl/vic_pkg.sv
// Package: shared constants and the vector computation for the two-level
// interrupt controller. Assumes source indices are ordered as the fixed
// tie-break order: ext0, tmr0, ext1, tmr1, serial.
package vic_pkg;
    localparam int NUM_SRC    = 5;
    localparam int NUM_EXT    = 2;
    localparam int NUM_TMR    = 2;
    localparam int VEC_W      = 16;
    localparam int VEC_BASE   = 3;
    localparam int VEC_STRIDE = 8;
    localparam int IDX_W      = $clog2(NUM_SRC);
    localparam int SER_IDX    = NUM_SRC - 1;

    // Vector address of a source index.
    function automatic logic [VEC_W-1:0] vec_of(input int idx);
        return VEC_W'(VEC_BASE + idx * VEC_STRIDE);
    endfunction
endpackage

// File: rtl/vic_ext_trigger.sv
// One external interrupt pin: level or falling-edge detection.
// Assumes the pin is already synchronous to clk. The edge flag exists only in
// edge mode and is held until the controller clears it on acknowledge.
module vic_ext_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_mode,
    input  logic pin_n,
    input  logic clr,
    output logic flag,
    output logic req
);
    logic prev_q;

    // Track pin history and latch falling edges while in edge mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            flag   <= 1'b0;
        end else begin
            prev_q <= pin_n;
            flag   <= edge_mode & ((flag & ~clr) | (prev_q & ~pin_n));
        end
    end

    // Request: latched flag in edge mode, raw low level otherwise.
    assign req = edge_mode ? flag : ~pin_n;

    assert_edge_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && !pin_n && $past(pin_n)) |=> flag);

    assert_flag_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && flag && !clr) |=> flag);
endmodule

// File: rtl/vic_arbiter.sv
// Picks the winning pending source: any high-priority source first, then the
// lowest index within the chosen group. Purely combinational.
module vic_arbiter #(
    parameter int N     = 5,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     pend,
    input  logic [N-1:0]     hi_mask,
    output logic             hit,
    output logic [IDX_W-1:0] win_idx,
    output logic             win_hi
);
    // Scan downwards so the lowest matching index is the one left standing.
    always_comb begin
        hit     = 1'b0;
        win_idx = '0;
        win_hi  = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i] && hi_mask[i]) begin
                hit     = 1'b1;
                win_idx = IDX_W'(i);
                win_hi  = 1'b1;
            end
        end
        if (!win_hi) begin
            for (int i = N - 1; i >= 0; i--) begin
                if (pend[i]) begin
                    hit     = 1'b1;
                    win_idx = IDX_W'(i);
                end
            end
        end
    end
endmodule

// File: rtl/vic_nest.sv
// In-service record for two priority levels. A return ends the highest active
// level; a push marks the level of the request just taken. The return is
// applied before the push when both occur in one cycle.
module vic_nest (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic push_hi,
    input  logic pop,
    output logic hi_act,
    output logic lo_act
);
    logic hi_nx, lo_nx;

    // Next in-service state: pop first, then push.
    always_comb begin
        hi_nx = hi_act;
        lo_nx = lo_act;
        if (pop) begin
            if (hi_act) hi_nx = 1'b0;
            else        lo_nx = 1'b0;
        end
        if (push) begin
            if (push_hi) hi_nx = 1'b1;
            else         lo_nx = 1'b1;
        end
    end

    // Register the in-service levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_act <= 1'b0;
            lo_act <= 1'b0;
        end else begin
            hi_act <= hi_nx;
            lo_act <= lo_nx;
        end
    end

    assert_hi_rise_needs_push_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_act) |-> $past(push && push_hi));
endmodule

// File: rtl/vic_two_level.sv
// Top: two-level vectored interrupt controller for five sources. Assumes all
// inputs are synchronous to clk and that the CPU asserts irq_ack only for one
// cycle while irq_req is high. Source order: ext0, tmr0, ext1, tmr1, serial.
module vic_two_level
    import vic_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               glb_en,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [NUM_SRC-1:0] src_pri,
    input  logic [NUM_EXT-1:0] ext_mode,
    input  logic [NUM_EXT-1:0] ext_pin_n,
    input  logic [NUM_TMR-1:0] tmr_ovf,
    input  logic               ser_flag,
    input  logic               irq_ack,
    input  logic               irq_ret,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vec,
    output logic [NUM_TMR-1:0] tmr_clr,
    output logic [NUM_EXT-1:0] ext_flag
);
    logic [NUM_SRC-1:0] src_req;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_EXT-1:0] ext_clr;
    logic               hit, win_hi, take, hi_act, lo_act;
    logic [IDX_W-1:0]   win_idx;

    // External pins sit at even indices, timers at odd ones.
    for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
        vic_ext_trigger u_trig (
            .clk       (clk),
            .rst_n     (rst_n),
            .edge_mode (ext_mode[k]),
            .pin_n     (ext_pin_n[k]),
            .clr       (ext_clr[k]),
            .flag      (ext_flag[k]),
            .req       (src_req[2*k])
        );
        assign ext_clr[k] = take && (win_idx == IDX_W'(2*k));
    end

    for (genvar k = 0; k < NUM_TMR; k++) begin : g_tmr
        assign src_req[2*k+1] = tmr_ovf[k];
        assign tmr_clr[k]     = take && (win_idx == IDX_W'(2*k+1));
    end

    assign src_req[SER_IDX] = ser_flag;
    assign pend = src_req & src_en & {NUM_SRC{glb_en}};

    vic_arbiter #(.N(NUM_SRC), .IDX_W(IDX_W)) u_arb (
        .pend    (pend),
        .hi_mask (src_pri),
        .hit     (hit),
        .win_idx (win_idx),
        .win_hi  (win_hi)
    );

    // Offer the winner only if it outranks every level now in service.
    always_comb begin
        irq_req = hit && !hi_act && (!lo_act || win_hi);
        irq_vec = irq_req ? vec_of(int'(win_idx)) : '0;
    end

    assign take = irq_ack && irq_req;

    vic_nest u_nest (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (take),
        .push_hi (win_hi),
        .pop     (irq_ret),
        .hi_act  (hi_act),
        .lo_act  (lo_act)
    );

    assert_master_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> glb_en);

    assert_vec_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec[2:0] == 3'b011));

    assert_tmr_clr_on_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|tmr_clr) |-> (irq_ack && $onehot(tmr_clr)));

    assert_lo_only_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_act && irq_req) |-> src_pri[win_idx]);

    assert_hi_blocks_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hi_act |-> !irq_req);

    assert_ret_pops_hi_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && hi_act) |=> !hi_act);
endmodule

// File: tb/vic_two_level_tb.sv
// Bench: behavioural reference model compared on every clock, plus directed
// checks with hand-computed expected values.
module vic_two_level_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        glb_en = 1'b0;
    logic [4:0]  src_en = '0;
    logic [4:0]  src_pri = '0;
    logic [1:0]  ext_mode = '0;
    logic [1:0]  ext_pin_n = 2'b11;
    logic [1:0]  tmr_ovf = '0;
    logic        ser_flag = 1'b0;
    logic        irq_ack = 1'b0;
    logic        irq_ret = 1'b0;
    logic        irq_req;
    logic [15:0] irq_vec;
    logic [1:0]  tmr_clr;
    logic [1:0]  ext_flag;

    int n_vec = 0;
    int n_bad = 0;
    string cur_req = "R12";

    // Model state.
    bit m_flag [2];
    bit m_prev [2] = '{1'b1, 1'b1};
    bit m_hi = 0;
    bit m_lo = 0;

    // Last sampled outputs.
    logic        o_req;
    logic [15:0] o_vec;
    logic [1:0]  o_clr;
    logic [1:0]  o_flag;

    always #10 clk = ~clk;

    vic_two_level u_dut (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .src_en(src_en),
        .src_pri(src_pri), .ext_mode(ext_mode), .ext_pin_n(ext_pin_n),
        .tmr_ovf(tmr_ovf), .ser_flag(ser_flag), .irq_ack(irq_ack),
        .irq_ret(irq_ret), .irq_req(irq_req), .irq_vec(irq_vec),
        .tmr_clr(tmr_clr), .ext_flag(ext_flag)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // One clock: compare at the falling edge, advance the model at the rising edge.
    task automatic tick();
        bit r[5];
        bit e_req, e_hi, found;
        int e_idx;
        logic [15:0] e_vec;
        logic [1:0]  e_clr;
        @(negedge clk);
        r[0] = ext_mode[0] ? m_flag[0] : !ext_pin_n[0];
        r[1] = tmr_ovf[0];
        r[2] = ext_mode[1] ? m_flag[1] : !ext_pin_n[1];
        r[3] = tmr_ovf[1];
        r[4] = ser_flag;
        found = 0; e_idx = 0; e_hi = 0;
        for (int i = 0; i < 5; i++)
            if (!found && r[i] && src_en[i] && glb_en && src_pri[i]) begin
                found = 1; e_idx = i; e_hi = 1;
            end
        for (int i = 0; i < 5; i++)
            if (!found && r[i] && src_en[i] && glb_en) begin
                found = 1; e_idx = i;
            end
        e_req = found && !m_hi && (!m_lo || e_hi);
        e_vec = e_req ? 16'(3 + 8 * e_idx) : 16'h0;
        e_clr = 2'b00;
        if (irq_ack && e_req && e_idx == 1) e_clr = 2'b01;
        if (irq_ack && e_req && e_idx == 3) e_clr = 2'b10;
        o_req = irq_req; o_vec = irq_vec; o_clr = tmr_clr; o_flag = ext_flag;
        n_vec++;
        if (o_req !== e_req || o_vec !== e_vec || o_clr !== e_clr ||
            o_flag !== {2'(m_flag[1]), 1'b0} + 2'(m_flag[0])) begin
            n_bad++;
            $display("FAIL %s model: req/vec/clr/flag got %0b/%0h/%0b/%0b expected %0b/%0h/%0b/%0b",
                     cur_req, o_req, o_vec, o_clr, o_flag, e_req, e_vec, e_clr,
                     {m_flag[1], m_flag[0]});
        end
        @(posedge clk);
        if (!rst_n) begin
            m_flag = '{0, 0}; m_prev = '{1, 1}; m_hi = 0; m_lo = 0;
        end else begin
            for (int k = 0; k < 2; k++) begin
                bit fall, clr;
                fall = m_prev[k] && !ext_pin_n[k];
                clr  = irq_ack && e_req && (e_idx == 2 * k);
                m_flag[k] = ext_mode[k] && ((m_flag[k] && !clr) || fall);
                m_prev[k] = ext_pin_n[k];
            end
            if (irq_ret) begin
                if (m_hi) m_hi = 0; else m_lo = 0;
            end
            if (irq_ack && e_req) begin
                if (e_hi) m_hi = 1; else m_lo = 1;
            end
        end
        #1;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        cur_req = "R12";
        chk("R12 req", 32'(o_req), 0);
        chk("R12 flags", 32'(o_flag), 0);
        chk("R12 vec", 32'(o_vec), 0);

        cur_req = "R1";
        src_en = 5'h1F; tmr_ovf = 2'b01;
        tick(); chk("R1 gated", 32'(o_req), 0);
        glb_en = 1'b1;
        tick(); chk("R3 tmr0 vec", 32'(o_vec), 32'h000B);

        cur_req = "R2";
        src_en = 5'h1D;
        tick(); chk("R2 disabled", 32'(o_req), 0);
        src_en = 5'h1F;

        cur_req = "R4";
        tmr_ovf = 2'b11; ser_flag = 1'b1;
        tick(); chk("R4 order tmr0", 32'(o_vec), 32'h000B);
        ext_pin_n = 2'b10;
        tick(); chk("R7 level ext0 same cycle", 32'(o_vec), 32'h0003);
        ext_pin_n = 2'b11;
        tick(); chk("R7 level release", 32'(o_vec), 32'h000B);

        cur_req = "R3";
        tmr_ovf = 2'b10;
        tick(); chk("R3 tmr1 vec", 32'(o_vec), 32'h001B);
        tmr_ovf = 2'b00;
        tick(); chk("R3 serial vec", 32'(o_vec), 32'h0023);
        ser_flag = 1'b0; ext_pin_n = 2'b01;
        tick(); chk("R3 ext1 vec", 32'(o_vec), 32'h0013);
        ext_pin_n = 2'b11;
        tick(); chk("R7 no flag", 32'(o_flag), 0);

        cur_req = "R5";
        tmr_ovf = 2'b01; ser_flag = 1'b1; src_pri = 5'h10;
        tick(); chk("R5 high serial wins", 32'(o_vec), 32'h0023);
        src_pri = 5'h00; ser_flag = 1'b0; tmr_ovf = 2'b00;

        cur_req = "R6";
        ext_mode = 2'b01;
        tick();
        ext_pin_n = 2'b10;
        tick();
        ext_pin_n = 2'b11;
        tick(); chk("R6 flag set", 32'(o_flag), 1); chk("R6 vec", 32'(o_vec), 32'h0003);
        tick(); chk("R6 flag held", 32'(o_flag), 1);

        cur_req = "R8";
        irq_ack = 1'b1;
        tick(); chk("R8 ack offered", 32'(o_req), 1);
        irq_ack = 1'b0;
        tick(); chk("R8 edge flag cleared", 32'(o_flag), 0);

        cur_req = "R9";
        tmr_ovf = 2'b10;
        tick(); chk("R9 low blocked", 32'(o_req), 0);
        src_pri = 5'h08;
        tick(); chk("R9 high preempts", 32'(o_vec), 32'h001B);
        irq_ack = 1'b1;
        tick(); chk("R8 timer clear pulse", 32'(o_clr), 2);
        irq_ack = 1'b0; tmr_ovf = 2'b00;

        cur_req = "R10";
        ser_flag = 1'b1; src_pri = 5'h18;
        tick(); chk("R10 high blocks", 32'(o_req), 0);

        cur_req = "R11";
        irq_ret = 1'b1;
        tick();
        irq_ret = 1'b0;
        tick(); chk("R11 pop high", 32'(o_vec), 32'h0023);
        irq_ret = 1'b1;
        tick();
        irq_ret = 1'b0; src_pri = 5'h00;
        tick(); chk("R11 pop low", 32'(o_vec), 32'h0023);

        cur_req = "R8";
        irq_ack = 1'b1;
        tick(); chk("R8 serial no clear pulse", 32'(o_clr), 0);
        irq_ack = 1'b0;
        tick(); chk("R9 same level blocked", 32'(o_req), 0);
        irq_ret = 1'b1;
        tick();
        irq_ret = 1'b0;
        tick(); chk("R8 serial still pending", 32'(o_vec), 32'h0023);

        cur_req = "R4";
        for (int n = 0; n < 400; n++) begin
            glb_en    = ($urandom % 8) != 0;
            src_en    = 5'($urandom);
            src_pri   = 5'($urandom);
            ext_mode  = 2'($urandom);
            ext_pin_n = 2'($urandom);
            tmr_ovf   = 2'($urandom);
            ser_flag  = 1'($urandom);
            irq_ack   = ($urandom % 3) == 0;
            irq_ret   = ($urandom % 4) == 0;
            tick();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule